// File: doc/BRIEF.md
# Wrap-configurable mesh neighbour interconnect

This block is the nearest-neighbour routing fabric for a square array of SIMD processing elements. Each element drives four directional output ports (up, down, left, right) from its own registers. The fabric delivers each of those values to the opposite-facing input port of the adjacent element in the same cycle. Every element therefore samples what its neighbours drove at the next clock edge, and all elements move data in lock-step.

The control unit issues four single-cycle strobes that join or split the array edges. One pair covers the vertical axis and one pair covers the horizontal axis. With both axes joined the array is a torus. With one axis joined it is a cylinder. With neither joined it is an open mesh, and an edge input that faces outward reads zero. The two axes hold their join state independently.

The data ports are flattened. Element (row r, column c) takes slot r*N+c, and each slot is W bits wide. Row 0 is the top row and column 0 is the leftmost column.

Top module: `mesh_link_net`

## Requirements
- R1: While reset is applied, and after it is released until a join command arrives, both axes are open, so the up inputs of row 0, the down inputs of row N-1, the left inputs of column 0 and the right inputs of column N-1 all read zero.
- R2: For rows r>0, the up input of (r,c) equals the down output of (r-1,c). For rows r<N-1, the down input of (r,c) equals the up output of (r+1,c). Both paths are combinational, so they hold in the same cycle the outputs are driven.
- R3: For columns c>0, the left input of (r,c) equals the right output of (r,c-1). For columns c<N-1, the right input of (r,c) equals the left output of (r,c+1). Both paths are combinational.
- R4: A vertical join strobe sampled at a clock edge joins the vertical axis from that edge on. After that, the up input of (0,c) equals the down output of (N-1,c), and the down input of (N-1,c) equals the up output of (0,c).
- R5: A horizontal join strobe sampled at a clock edge joins the horizontal axis from that edge on. After that, the left input of (r,0) equals the right output of (r,N-1), and the right input of (r,N-1) equals the left output of (r,0).
- R6: A split strobe on an axis sampled at a clock edge returns that axis to open from that edge on, and its edge-facing inputs read zero again.
- R7: A strobe on one axis leaves the join state of the other axis unchanged.
- R8: When the join and split strobes of one axis are high in the same cycle, the split wins and the axis ends up open.
- R9: When an axis sees no strobe, its join state is held across any number of cycles.
- R10: Element (r,c) occupies bits [(r*N+c)*W +: W] of every flattened port bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vert_join | input | 1 | Strobe: join the top and bottom edges |
| vert_split | input | 1 | Strobe: open the top and bottom edges (wins over vert_join) |
| horz_join | input | 1 | Strobe: join the left and right edges |
| horz_split | input | 1 | Strobe: open the left and right edges (wins over horz_join) |
| tx_up | input | N*N*W | Up-facing output port of every element |
| tx_dn | input | N*N*W | Down-facing output port of every element |
| tx_lt | input | N*N*W | Left-facing output port of every element |
| tx_rt | input | N*N*W | Right-facing output port of every element |
| rx_up | output | N*N*W | Up-facing input port of every element |
| rx_dn | output | N*N*W | Down-facing input port of every element |
| rx_lt | output | N*N*W | Left-facing input port of every element |
| rx_rt | output | N*N*W | Right-facing input port of every element |

## Verification
The bench builds the block as a 4x4 array with 8-bit ports. At that size there are interior elements, edge elements and corner elements, and the bench compares every one of the 64 routed ports against a coordinate-based model after each step. Each element and direction gets a distinct nonzero value with the top bit set, so a wrong neighbour, a swapped slot or a missing wrap shows up as a mismatch rather than as an accidental match. The default 8x8 array uses the same generate loops at a larger count.

// File: rtl/mesh_link_pkg.sv
package mesh_link_pkg;

  // Join state of the two array axes.
  typedef struct packed {
    logic vert;
    logic horz;
  } join_state_t;

endpackage

// File: rtl/axis_join_reg.sv
// Holds the join state of one axis; split beats join on the same edge.
module axis_join_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic join_cmd,
  input  logic split_cmd,
  output logic joined_q
);

  logic upd_en;
  logic joined_d;

  always_comb begin
    upd_en   = join_cmd | split_cmd;
    joined_d = join_cmd & ~split_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      joined_q <= 1'b0;
    end else if (upd_en) begin
      joined_q <= joined_d;
    end
  end

  // R8
  split_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_cmd |=> !joined_q);

  // R4
  join_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_cmd && !split_cmd) |=> joined_q);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_cmd && !split_cmd) |=> $stable(joined_q));

endmodule

// File: rtl/lane_route.sv
// One line of N elements along an axis. "prv" is the port facing index 0
// (up or left), "nxt" is the port facing index N-1 (down or right).
module lane_route #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           joined,
  input  logic [N*W-1:0] prv_tx,
  input  logic [N*W-1:0] nxt_tx,
  output logic [N*W-1:0] prv_rx,
  output logic [N*W-1:0] nxt_rx
);

  localparam int LAST = N - 1;

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i == 0) begin : g_head
      assign prv_rx[i*W +: W] = joined ? nxt_tx[LAST*W +: W] : '0;
    end else begin : g_body_p
      assign prv_rx[i*W +: W] = nxt_tx[(i-1)*W +: W];
    end

    if (i == LAST) begin : g_tail
      assign nxt_rx[i*W +: W] = joined ? prv_tx[0 +: W] : '0;
    end else begin : g_body_n
      assign nxt_rx[i*W +: W] = prv_tx[(i+1)*W +: W];
    end
  end

endmodule

// File: rtl/mesh_link_net.sv
module mesh_link_net
  import mesh_link_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vert_join,
  input  logic             vert_split,
  input  logic             horz_join,
  input  logic             horz_split,
  input  logic [N*N*W-1:0] tx_up,
  input  logic [N*N*W-1:0] tx_dn,
  input  logic [N*N*W-1:0] tx_lt,
  input  logic [N*N*W-1:0] tx_rt,
  output logic [N*N*W-1:0] rx_up,
  output logic [N*N*W-1:0] rx_dn,
  output logic [N*N*W-1:0] rx_lt,
  output logic [N*N*W-1:0] rx_rt
);

  localparam int LANEW = N * W;
  localparam int BOT0  = (N - 1) * N;   // slot of bottom-left element
  localparam int RGT0  = N - 1;         // slot of top-right element

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_s = rst_pipe[1];

  join_state_t jst;

  axis_join_reg u_vert (
    .clk       (clk),
    .rst_n     (rst_s),
    .join_cmd  (vert_join),
    .split_cmd (vert_split),
    .joined_q  (jst.vert)
  );

  axis_join_reg u_horz (
    .clk       (clk),
    .rst_n     (rst_s),
    .join_cmd  (horz_join),
    .split_cmd (horz_split),
    .joined_q  (jst.horz)
  );

  // Columns: lanes along the vertical axis.
  for (genvar k = 0; k < N; k++) begin : g_col
    logic [LANEW-1:0] up_tx, dn_tx, up_rx, dn_rx;
    for (genvar r = 0; r < N; r++) begin : g_cell
      assign up_tx[r*W +: W]          = tx_up[(r*N+k)*W +: W];
      assign dn_tx[r*W +: W]          = tx_dn[(r*N+k)*W +: W];
      assign rx_up[(r*N+k)*W +: W]    = up_rx[r*W +: W];
      assign rx_dn[(r*N+k)*W +: W]    = dn_rx[r*W +: W];
    end
    lane_route #(.N(N), .W(W)) u_lane (
      .joined (jst.vert),
      .prv_tx (up_tx),
      .nxt_tx (dn_tx),
      .prv_rx (up_rx),
      .nxt_rx (dn_rx)
    );
  end

  // Rows: lanes along the horizontal axis.
  for (genvar k = 0; k < N; k++) begin : g_row
    logic [LANEW-1:0] lt_tx, rt_tx, lt_rx, rt_rx;
    for (genvar c = 0; c < N; c++) begin : g_cell
      assign lt_tx[c*W +: W]          = tx_lt[(k*N+c)*W +: W];
      assign rt_tx[c*W +: W]          = tx_rt[(k*N+c)*W +: W];
      assign rx_lt[(k*N+c)*W +: W]    = lt_rx[c*W +: W];
      assign rx_rt[(k*N+c)*W +: W]    = rt_rx[c*W +: W];
    end
    lane_route #(.N(N), .W(W)) u_lane (
      .joined (jst.horz),
      .prv_tx (lt_tx),
      .nxt_tx (rt_tx),
      .prv_rx (lt_rx),
      .nxt_rx (rt_rx)
    );
  end

  // R1
  reset_open_chk: assert property (@(posedge clk)
    !rst_s |-> (rx_up[0 +: W] == '0 && rx_lt[0 +: W] == '0));

  // R4
  vert_wrap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(vert_join && !vert_split && rst_s) |->
      (rx_dn[BOT0*W +: W] == tx_up[0 +: W] && rx_up[0 +: W] == tx_dn[BOT0*W +: W]));

  // R5
  horz_wrap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(horz_join && !horz_split && rst_s) |->
      (rx_rt[RGT0*W +: W] == tx_lt[0 +: W] && rx_lt[0 +: W] == tx_rt[RGT0*W +: W]));

  // R6
  vert_open_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(vert_split && rst_s) |->
      (rx_up[0 +: W] == '0 && rx_dn[BOT0*W +: W] == '0));

  // R6
  horz_open_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(horz_split && rst_s) |->
      (rx_lt[0 +: W] == '0 && rx_rt[RGT0*W +: W] == '0));

endmodule

// File: tb/mesh_link_net_test.sv
`timescale 1ns/1ps
module mesh_link_net_test;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NN = N * N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic vj, vs, hj, hs;
  logic [NN*W-1:0] tx_up, tx_dn, tx_lt, tx_rt;
  logic [NN*W-1:0] rx_up, rx_dn, rx_lt, rx_rt;
  logic [W-1:0] txa [4][NN];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  mesh_link_net #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .vert_join(vj), .vert_split(vs), .horz_join(hj), .horz_split(hs),
    .tx_up(tx_up), .tx_dn(tx_dn), .tx_lt(tx_lt), .tx_rt(tx_rt),
    .rx_up(rx_up), .rx_dn(rx_dn), .rx_lt(rx_lt), .rx_rt(rx_rt)
  );

  // Step vectors: {vj, vs, hj, hs, expected vert, expected horz}
  localparam logic [5:0] VEC [12] = '{
    6'b0000_00,  // idle after reset (R1, R9)
    6'b1000_10,  // join vertical (R4)
    6'b0010_11,  // join horizontal, vertical kept (R5, R7)
    6'b0100_01,  // split vertical, horizontal kept (R6, R7)
    6'b1100_01,  // join+split vertical while open (R8)
    6'b1000_11,  // join vertical again (R4)
    6'b1100_01,  // join+split vertical while joined (R8)
    6'b0000_01,  // idle (R9)
    6'b0011_00,  // join+split horizontal while joined (R8)
    6'b1010_11,  // join both (R4, R5)
    6'b0001_10,  // split horizontal only (R6, R7)
    6'b0000_10   // idle (R9)
  };

  task automatic load_tx(input int seed);
    for (int d = 0; d < 4; d++)
      for (int i = 0; i < NN; i++)
        txa[d][i] = W'(seed * 37 + d * 16 + i * 5 + 1) | 8'h80;
    for (int i = 0; i < NN; i++) begin
      tx_up[i*W +: W] = txa[0][i];
      tx_dn[i*W +: W] = txa[1][i];
      tx_lt[i*W +: W] = txa[2][i];
      tx_rt[i*W +: W] = txa[3][i];
    end
  endtask

  // Model by coordinates: d = 0 up, 1 down, 2 left, 3 right.
  function automatic logic [W-1:0] exp_rx(int d, int r, int c, bit vw, bit hw);
    case (d)
      0: return (r > 0)   ? txa[1][(r-1)*N+c] : (vw ? txa[1][(N-1)*N+c] : '0);
      1: return (r < N-1) ? txa[0][(r+1)*N+c] : (vw ? txa[0][c] : '0);
      2: return (c > 0)   ? txa[3][r*N+c-1]   : (hw ? txa[3][r*N+N-1] : '0);
      default: return (c < N-1) ? txa[2][r*N+c+1] : (hw ? txa[2][r*N] : '0);
    endcase
  endfunction

  function automatic logic [W-1:0] got_rx(int d, int i);
    case (d)
      0: return rx_up[i*W +: W];
      1: return rx_dn[i*W +: W];
      2: return rx_lt[i*W +: W];
      default: return rx_rt[i*W +: W];
    endcase
  endfunction

  // One check per direction over the whole array (R10 slot layout throughout).
  task automatic check_all(input bit vw, input bit hw, input string req);
    for (int d = 0; d < 4; d++) begin
      bit bad = 1'b0;
      n_run++;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          if (!bad && got_rx(d, r*N+c) !== exp_rx(d, r, c, vw, hw)) begin
            bad = 1'b1;
            n_fail++;
            $display("FAIL %s R10 dir=%0d elem=(%0d,%0d) actual=%h expected=%h",
                     req, d, r, c, got_rx(d, r*N+c), exp_rx(d, r, c, vw, hw));
          end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    vj = 1'b0; vs = 1'b0; hj = 1'b0; hs = 1'b0;
    load_tx(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all(1'b0, 1'b0, "R1 after release");

    // Table walk
    for (int s = 0; s < 12; s++) begin
      {vj, vs, hj, hs} = VEC[s][5:2];
      load_tx(s + 2);
      @(posedge clk);
      @(negedge clk);
      vj = 1'b0; vs = 1'b0; hj = 1'b0; hs = 1'b0;
      check_all(VEC[s][1], VEC[s][0], "R2/R3/R4/R5/R6/R7/R8/R9 step");
    end

    // Combinational same-cycle routing with vertical joined
    @(negedge clk);
    load_tx(99);
    #1;
    check_all(1'b1, 1'b0, "R2/R3/R4 same cycle");

    // Long hold of torus state
    vj = 1'b1; hj = 1'b1;
    @(negedge clk);
    vj = 1'b0; hj = 1'b0;
    repeat (5) @(negedge clk);
    load_tx(123);
    #1;
    check_all(1'b1, 1'b1, "R9 held torus");

    // Reset in the middle of operation opens both axes at once
    rst_n = 1'b0;
    #1;
    check_all(1'b0, 1'b0, "R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all(1'b0, 1'b0, "R1 open after re-release");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule